// File: doc/BRIEF.md
# LED Blink and Dimming Output Stage

This block is the output side of an I/O expander meant to drive LEDs. Each line has two output values: a phase-0 value and a phase-1 value. With blinking off, a line shows its phase-0 value. With blinking on, a free-running timer swaps every line between its two values after a fixed number of clocks. Adjacent lines form pairs. Each pair gets a PWM brightness that combines one global master level with a 4-bit level for that pair. An LED is taken as lit when its line is low, so the idle level is high.

Software reaches the block through a simple byte register bus: a write strobe, an 8-bit address, write data, and combinational read data. The register map depends on the line count: 8 lines use a bank stride of 1 and 16 lines use a stride of 2. If only the input, phase-0 and direction registers are used, the block behaves as a plain GPIO expander. A line set as an input is never driven.

Top module: `led_blink_expander`

## Requirements
- R1: After reset every line is an input (`pin_oe` all 0, `pin_out` all 1). Both output value sets and the direction registers read 0xFF. The master level, the blink control and all pair levels read 0.
- R2: With stride S = NLINES/8 and port k, the byte registers sit at these addresses: input pins at k, phase-0 values at S+k, direction at 3S+k, phase-1 values at 8+S+k. The master level is at 0x0E, blink control at 0x0F and pair levels at 0x10 onward. Any other address reads 0, and a write to it changes nothing.
- R3: A direction bit of 1 makes its line an input, with `pin_oe` 0 and `pin_out` 1, whatever the blink and PWM state. A direction bit of 0 sets `pin_oe` to 1.
- R4: While blinking is off, each output line uses its phase-0 value.
- R5: Blinking is on while bit 0 of the blink control is 1. The phase starts at 0, and it flips each time HALF_PERIOD clocks have passed with blinking on. Phase 1 selects the phase-1 values. Turning blinking off returns the phase to 0 and restarts the count.
- R6: A master level of 0 turns PWM off: every output line drives its selected value continuously.
- R7: With a nonzero master level m and pair level n, the duty is ((m+1)*(n+1))>>4, which ranges from 0 to 16. A 4-bit PWM counter starts at 0 after reset and adds 1 every clock. A line drives its selected value while the counter is below the duty, and 1 otherwise.
- R8: Pair p is lines 2p and 2p+1. Byte j of the pair levels holds pair 2j in bits 3:0 and pair 2j+1 in bits 7:4.
- R9: Only bit 0 of the blink control is stored. The other bits are ignored and read as 0. The master level register stores bits 3:0 only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| pin_in | input | NLINES | Sampled pin levels |
| pin_out | output | NLINES | Effective output level per line |
| pin_oe | output | NLINES | Output enable per line, 1 = driven |

## Verification
The bench builds the block with NLINES = 16 and HALF_PERIOD = 5. Sixteen lines bring the stride-2 map within reach, including the unmapped holes between banks, two ports per bank and four pair-level bytes. A half-period of 5 makes the blink phase flip hundreds of times in a short run, so phase flips can line up with writes, with blink turn-off and with every PWM counter value.

// File: rtl/lbx_pkg.sv
package lbx_pkg;
   localparam int PWM_W = 4;
   localparam logic [7:0] MASTER_ADDR = 8'h0E;
   localparam logic [7:0] BLINK_ADDR  = 8'h0F;
   localparam logic [7:0] LEVEL_ADDR  = 8'h10;
   localparam int         PHASE1_OFS  = 8;

   // duty in 0..16 from master level m and pair level n
   function automatic logic [PWM_W:0] pwm_duty(input logic [3:0] m, input logic [3:0] n);
      logic [8:0] prod;
      prod = ({5'd0, m} + 9'd1) * ({5'd0, n} + 9'd1);
      return prod[8:4];
   endfunction
endpackage

// File: rtl/lbx_regs.sv
module lbx_regs #(
   parameter int NLINES = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [7:0]        bus_addr,
   input  logic [7:0]        bus_wdata,
   input  logic [NLINES-1:0] pin_in,
   output logic [7:0]        bus_rdata,
   output logic [NLINES-1:0] val_ph0,
   output logic [NLINES-1:0] val_ph1,
   output logic [NLINES-1:0] dir_in,
   output logic [3:0]        master_lvl,
   output logic              blink_on,
   output logic [2*NLINES-1:0] pair_lvl
);
   import lbx_pkg::*;
   localparam int NPORTS  = NLINES / 8;
   localparam int STRIDE  = NLINES / 8;
   localparam int NLVLB   = NLINES / 4;
   localparam int PH0_A   = STRIDE;
   localparam int DIR_A   = 3 * STRIDE;
   localparam int PH1_A   = PHASE1_OFS + STRIDE;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         val_ph0    <= '1;
         val_ph1    <= '1;
         dir_in     <= '1;
         master_lvl <= '0;
         blink_on   <= 1'b0;
         pair_lvl   <= '0;
      end else if (bus_wr) begin
         for (int k = 0; k < NPORTS; k++) begin
            if (bus_addr == 8'(PH0_A + k)) val_ph0[8*k +: 8] <= bus_wdata;
            if (bus_addr == 8'(DIR_A + k)) dir_in[8*k +: 8]  <= bus_wdata;
            if (bus_addr == 8'(PH1_A + k)) val_ph1[8*k +: 8] <= bus_wdata;
         end
         for (int j = 0; j < NLVLB; j++) begin
            if (bus_addr == LEVEL_ADDR + 8'(j)) pair_lvl[8*j +: 8] <= bus_wdata;
         end
         if (bus_addr == MASTER_ADDR) master_lvl <= bus_wdata[3:0];
         if (bus_addr == BLINK_ADDR)  blink_on   <= bus_wdata[0];
      end
   end

   always_comb begin
      bus_rdata = 8'h00;
      for (int k = 0; k < NPORTS; k++) begin
         if (bus_addr == 8'(k))         bus_rdata = pin_in[8*k +: 8];
         if (bus_addr == 8'(PH0_A + k)) bus_rdata = val_ph0[8*k +: 8];
         if (bus_addr == 8'(DIR_A + k)) bus_rdata = dir_in[8*k +: 8];
         if (bus_addr == 8'(PH1_A + k)) bus_rdata = val_ph1[8*k +: 8];
      end
      for (int j = 0; j < NLVLB; j++) begin
         if (bus_addr == LEVEL_ADDR + 8'(j)) bus_rdata = pair_lvl[8*j +: 8];
      end
      if (bus_addr == MASTER_ADDR) bus_rdata = {4'h0, master_lvl};
      if (bus_addr == BLINK_ADDR)  bus_rdata = {7'h00, blink_on};
   end

   // R9
   blink_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == BLINK_ADDR) |=> (bus_rdata == 8'h00 || bus_addr != BLINK_ADDR
         || blink_on == $past(bus_wdata[0])));
endmodule

// File: rtl/lbx_blink_timer.sv
module lbx_blink_timer #(
   parameter int HALF_PERIOD = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   output logic phase
);
   localparam int CW = (HALF_PERIOD > 2) ? $clog2(HALF_PERIOD) : 1;
   localparam logic [CW-1:0] LAST = CW'(HALF_PERIOD - 1);

   logic [CW-1:0] count;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
         phase <= 1'b0;
      end else if (!enable) begin
         count <= '0;
         phase <= 1'b0;
      end else if (count == LAST) begin
         count <= '0;
         phase <= ~phase;
      end else begin
         count <= count + 1'b1;
      end
   end

   // R5
   phase_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !phase);
   // R5
   phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && count != LAST) |=> $stable(phase));
   // R5
   count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count <= LAST);
endmodule

// File: rtl/lbx_pwm_lane.sv
module lbx_pwm_lane (
   input  logic [3:0] master_lvl,
   input  logic [3:0] level,
   input  logic [3:0] pwm_cnt,
   output logic       lit
);
   import lbx_pkg::*;
   logic [PWM_W:0] duty;

   always_comb begin
      duty = pwm_duty(master_lvl, level);
      lit  = (master_lvl == 4'h0) || ({1'b0, pwm_cnt} < duty);
   end
endmodule

// File: rtl/led_blink_expander.sv
module led_blink_expander #(
   parameter int NLINES      = 8,
   parameter int HALF_PERIOD = 1000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [7:0]        bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic [NLINES-1:0] pin_in,
   output logic [NLINES-1:0] pin_out,
   output logic [NLINES-1:0] pin_oe
);
   import lbx_pkg::*;
   localparam int NPAIRS = NLINES / 2;
   localparam logic [7:0] DIR_A = 8'(3 * (NLINES / 8));

   if (!(NLINES == 8 || NLINES == 16)) begin : g_bad_lines
      $error("NLINES must be 8 or 16");
   end
   if (HALF_PERIOD < 2) begin : g_bad_half
      $error("HALF_PERIOD must be at least 2");
   end

   logic [NLINES-1:0]   val_ph0, val_ph1, dir_in, sel_val;
   logic [3:0]          master_lvl;
   logic                blink_on, phase;
   logic [2*NLINES-1:0] pair_lvl;
   logic [PWM_W-1:0]    pwm_cnt;
   logic [NPAIRS-1:0]   lit;

   lbx_regs #(.NLINES(NLINES)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .pin_in(pin_in), .bus_rdata(bus_rdata),
      .val_ph0(val_ph0), .val_ph1(val_ph1), .dir_in(dir_in),
      .master_lvl(master_lvl), .blink_on(blink_on), .pair_lvl(pair_lvl)
   );

   lbx_blink_timer #(.HALF_PERIOD(HALF_PERIOD)) u_timer (
      .clk(clk), .rst_n(rst_n), .enable(blink_on), .phase(phase)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pwm_cnt <= '0;
      else        pwm_cnt <= pwm_cnt + 1'b1;
   end

   for (genvar p = 0; p < NPAIRS; p++) begin : g_pair
      lbx_pwm_lane u_lane (
         .master_lvl(master_lvl), .level(pair_lvl[4*p +: 4]),
         .pwm_cnt(pwm_cnt), .lit(lit[p])
      );
   end

   assign sel_val = phase ? val_ph1 : val_ph0;

   always_comb begin
      for (int i = 0; i < NLINES; i++) begin
         pin_oe[i]  = ~dir_in[i];
         pin_out[i] = dir_in[i] ? 1'b1 : (lit[i/2] ? sel_val[i] : 1'b1);
      end
   end

   // R3
   dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == DIR_A) |=> (pin_oe[7:0] == ~$past(bus_wdata)));
   // R3
   input_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == DIR_A && bus_wdata[0]) |=> pin_out[0]);
endmodule

// File: tb/led_blink_expander_tb.sv
module led_blink_expander_tb;
   localparam int NL   = 16;
   localparam int HALF = 5;
   localparam int S    = NL / 8;
   localparam int NP   = NL / 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0;
   logic [7:0]    bus_addr = 8'h00;
   logic [7:0]    bus_wdata = 8'h00;
   logic [7:0]    bus_rdata;
   logic [NL-1:0] pin_in = '0;
   logic [NL-1:0] pin_out, pin_oe;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   led_blink_expander #(.NLINES(NL), .HALF_PERIOD(HALF)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe)
   );

   // reference state built from the requirements
   logic [NL-1:0]   m_ph0, m_ph1, m_dir;
   logic [3:0]      m_master;
   logic            m_blink, m_phase;
   logic [2*NL-1:0] m_lvl;
   logic [3:0]      m_pwm;
   int              m_tcnt;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ph0 <= '1; m_ph1 <= '1; m_dir <= '1;
         m_master <= 4'h0; m_blink <= 1'b0; m_lvl <= '0;
         m_pwm <= 4'h0; m_phase <= 1'b0; m_tcnt <= 0;
      end else begin
         if (bus_wr) begin
            for (int k = 0; k < NP; k++) begin
               if (bus_addr == 8'(S + k))     m_ph0[8*k +: 8] <= bus_wdata;
               if (bus_addr == 8'(3*S + k))   m_dir[8*k +: 8] <= bus_wdata;
               if (bus_addr == 8'(8 + S + k)) m_ph1[8*k +: 8] <= bus_wdata;
            end
            for (int j = 0; j < NL/4; j++)
               if (bus_addr == 8'(16 + j)) m_lvl[8*j +: 8] <= bus_wdata;
            if (bus_addr == 8'h0E) m_master <= bus_wdata[3:0];
            if (bus_addr == 8'h0F) m_blink  <= bus_wdata[0];
         end
         m_pwm <= m_pwm + 4'd1;
         if (!m_blink) begin
            m_tcnt <= 0; m_phase <= 1'b0;
         end else if (m_tcnt == HALF - 1) begin
            m_tcnt <= 0; m_phase <= ~m_phase;
         end else begin
            m_tcnt <= m_tcnt + 1;
         end
      end
   end

   function automatic logic exp_line(int i);
      logic sel;
      int duty, n;
      if (m_dir[i]) return 1'b1;
      sel = m_phase ? m_ph1[i] : m_ph0[i];
      if (m_master == 4'h0) return sel;
      n = int'(m_lvl[4*(i/2) +: 4]);
      duty = ((int'(m_master) + 1) * (n + 1)) / 16;
      return (int'(m_pwm) < duty) ? sel : 1'b1;
   endfunction

   function automatic logic [7:0] exp_rd(logic [7:0] a);
      logic [7:0] r;
      r = 8'h00;
      for (int k = 0; k < NP; k++) begin
         if (a == 8'(k))         r = pin_in[8*k +: 8];
         if (a == 8'(S + k))     r = m_ph0[8*k +: 8];
         if (a == 8'(3*S + k))   r = m_dir[8*k +: 8];
         if (a == 8'(8 + S + k)) r = m_ph1[8*k +: 8];
      end
      for (int j = 0; j < NL/4; j++)
         if (a == 8'(16 + j)) r = m_lvl[8*j +: 8];
      if (a == 8'h0E) r = {4'h0, m_master};
      if (a == 8'h0F) r = {7'h00, m_blink};
      return r;
   endfunction

   task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic compare();
      logic [NL-1:0] e_out;
      string tag;
      int bad;
      bad = -1;
      for (int i = 0; i < NL; i++) begin
         e_out[i] = exp_line(i);
         if (bad < 0 && e_out[i] !== pin_out[i]) bad = i;
      end
      if (bad < 0) tag = "R4 line";
      else if (m_dir[bad]) tag = "R3 input line";
      else if (m_master != 0) tag = "R7 R8 pwm line";
      else if (m_blink) tag = "R5 R6 blink line";
      else tag = "R4 R6 static line";
      chk(pin_out === e_out, tag, 32'(pin_out), 32'(e_out));
      chk(pin_oe === ~m_dir, "R3 output enable", 32'(pin_oe), 32'(~m_dir));
      if (bus_addr == 8'h0F) tag = "R9 blink readback";
      else if (bus_addr >= 8'h10 && bus_addr < 8'(16 + NL/4)) tag = "R8 level readback";
      else tag = "R2 readback";
      chk(bus_rdata === exp_rd(bus_addr), tag, 32'(bus_rdata), 32'(exp_rd(bus_addr)));
   endtask

   task automatic tick(bit wr, logic [7:0] a, logic [7:0] d);
      bus_wr = wr; bus_addr = a; bus_wdata = d; pin_in = NL'($urandom);
      @(posedge clk);
      @(negedge clk);
      bus_wr = 1'b0;
      compare();
   endtask

   task automatic idle(int n);
      for (int c = 0; c < n; c++) tick(1'b0, 8'($urandom_range(0, 31)), 8'h00);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R1 reset state at the pins and registers
      chk(pin_out === '1, "R1 reset pin_out", 32'(pin_out), 32'hFFFF);
      chk(pin_oe === '0, "R1 reset pin_oe", 32'(pin_oe), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      bus_addr = 8'(3*S);
      #1 chk(bus_rdata === 8'hFF, "R1 reset direction", 32'(bus_rdata), 32'hFF);
      bus_addr = 8'h0E;
      #1 chk(bus_rdata === 8'h00, "R1 reset master", 32'(bus_rdata), 32'h0);
      bus_addr = 8'(8 + S);
      #1 chk(bus_rdata === 8'hFF, "R1 reset phase1", 32'(bus_rdata), 32'hFF);
      // R4 plain outputs
      tick(1'b1, 8'(3*S), 8'h00);
      tick(1'b1, 8'(3*S + 1), 8'h00);
      tick(1'b1, 8'(S), 8'h5A);
      tick(1'b1, 8'(S + 1), 8'hC3);
      idle(4);
      // R5 blinking, R9 ignored upper bits
      tick(1'b1, 8'(8 + S), 8'hA5);
      tick(1'b1, 8'(8 + S + 1), 8'h3C);
      tick(1'b1, 8'h0F, 8'hFF);
      idle(23);
      tick(1'b1, 8'h0F, 8'hFE);
      idle(4);
      tick(1'b1, 8'h0F, 8'h01);
      idle(12);
      // R7 R8 dimming, full and partial
      tick(1'b1, 8'h0E, 8'hFF);
      tick(1'b1, 8'h10, 8'hF0);
      tick(1'b1, 8'h11, 8'h7A);
      tick(1'b1, 8'h12, 8'h31);
      tick(1'b1, 8'h13, 8'h0F);
      idle(34);
      tick(1'b1, 8'h0E, 8'h03);
      idle(20);
      // R3 half the lines as inputs
      tick(1'b1, 8'(3*S), 8'hF0);
      idle(10);
      // R2 unmapped writes change nothing
      tick(1'b1, 8'h04, 8'h00);
      tick(1'b1, 8'h09, 8'h00);
      tick(1'b1, 8'h1F, 8'h00);
      for (int a = 0; a < 24; a++) tick(1'b0, 8'(a), 8'h00);
      // random traffic
      for (int c = 0; c < 3000; c++) begin
         logic [7:0] a, d;
         a = 8'($urandom_range(0, 31));
         d = 8'($urandom);
         if (a == 8'(3*S) || a == 8'(3*S + 1)) d = d & 8'($urandom) & 8'($urandom);
         tick($urandom_range(0, 2) == 0, a, d);
      end
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      for (int c = 0; c < 100000; c++) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule